// File: doc/BRIEF.md
# Transactional FIFO with commit and rollback

This is a single-clock FIFO whose writes stay provisional until the writer confirms them. Each accepted write takes a slot at once, but the reader cannot see it yet. A commit strobe publishes the whole batch of writes made since the last commit or rollback. A rollback strobe discards that batch and returns its slots to the free pool. Either strobe also covers a write made in the same cycle.

The read side uses first-word-fall-through: the oldest committed word is shown on `data_o` whenever `valid_o` is high, and a `got_i` pulse consumes it. Full depends on every occupied slot, including the provisional ones. Valid depends only on the committed words. The FIFO can therefore be full and have nothing to read at the same time.

Two coarse level outputs quantise the committed fill and the guaranteed free space to 2^N steps. A level width of 0 turns the indicator off. The storage is a register array. The requested depth is rounded up to the next power of two.

Top module: `txn_fifo`

## Requirements
- R1: After reset, `valid_o` and `full_o` are 0, `fill_lvl_o` is 0, and `free_lvl_o` shows the whole depth as free.
- R2: Committed words come out on `data_o` in the order they were written, and the head word is shown whenever `valid_o` is 1.
- R3: Words written after the last commit or rollback are not readable. `valid_o` depends only on committed words.
- R4: A commit publishes every pending write, including a put in the same cycle. From the next cycle those words are readable.
- R5: A rollback discards every pending write, including a put in the same cycle. Their slots are free again from the next cycle.
- R6: `full_o` is 1 exactly when unread committed words plus pending words equal the depth. It may be 1 while `valid_o` is 0.
- R7: A put while `full_o` is 1 is ignored. No word is stored and nothing later appears for it.
- R8: A got while `valid_o` is 0 is ignored and changes no state.
- R9: `fill_lvl_o` (N bits) equals min(2^N-1, floor(committed_unread * 2^N / DEPTH)).
- R10: `free_lvl_o` (N bits) equals min(2^N-1, floor(free_slots * 2^N / DEPTH)), where free_slots = DEPTH - committed_unread - pending.
- R11: DEPTH is MIN_DEPTH rounded up to a power of two. With MIN_DEPTH = 12, exactly 16 writes are accepted before `full_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| put_i | input | 1 | Write strobe |
| data_i | input | DATA_W | Write data |
| commit_i | input | 1 | Publish pending writes |
| rollback_i | input | 1 | Discard pending writes |
| full_o | output | 1 | No free slot |
| free_lvl_o | output | max(1,FREE_QW) | Quantised guaranteed free space |
| got_i | input | 1 | Consume head word |
| data_o | output | DATA_W | Head word |
| valid_o | output | 1 | Head word is committed and present |
| fill_lvl_o | output | max(1,FILL_QW) | Quantised committed fill |

## Verification
The assertions assume that `commit_i` and `rollback_i` are never high in the same cycle, because the resulting state is undefined. Under that assumption they check:
- the committed pointer never passes the tentative one;
- occupancy never exceeds DEPTH;
- refused puts and gots leave the pointers unchanged.

The stimulus draws at most one of the two strobes per cycle. It also includes puts while full, gots while empty, and strobes that coincide with a put.

// File: rtl/txn_fifo_pkg.sv
package txn_fifo_pkg;
  typedef enum logic [1:0] {
    WR_HOLD     = 2'd0,
    WR_COMMIT   = 2'd1,
    WR_ROLLBACK = 2'd2
  } wr_op_e;

  function automatic int pow2_ceil_log(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/txn_fifo_ptrs.sv
module txn_fifo_ptrs
  import txn_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          put_i,
  input  logic          commit_i,
  input  logic          rollback_i,
  input  logic          got_i,
  output logic          full_o,
  output logic          valid_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW:0]   used_o,
  output logic [AW:0]   occ_o
);
  logic [AW:0] rd_q, cw_q, tw_q, tw_adv;
  logic        put_ok, got_ok;
  wr_op_e      op;

  assign occ_o     = tw_q - rd_q;
  assign used_o    = cw_q - rd_q;
  assign full_o    = occ_o[AW];
  assign valid_o   = (cw_q != rd_q);
  assign put_ok    = put_i & ~full_o;
  assign got_ok    = got_i & valid_o;
  assign tw_adv    = tw_q + {{AW{1'b0}}, put_ok};
  assign wr_en_o   = put_ok;
  assign wr_addr_o = tw_q[AW-1:0];
  assign rd_addr_o = rd_q[AW-1:0];

  always_comb begin
    if (commit_i)        op = WR_COMMIT;
    else if (rollback_i) op = WR_ROLLBACK;
    else                 op = WR_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      cw_q <= '0;
      tw_q <= '0;
    end else begin
      rd_q <= rd_q + {{AW{1'b0}}, got_ok};
      unique case (op)
        WR_COMMIT: begin
          cw_q <= tw_adv;
          tw_q <= tw_adv;
        end
        WR_ROLLBACK: tw_q <= cw_q;
        default:     tw_q <= tw_adv;
      endcase
    end
  end

  // Occupancy never exceeds the depth.
  assert_occ_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_o <= (AW+1)'(1 << AW));
  // Committed words are a subset of the occupied slots.
  assert_commit_within_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_o <= occ_o);
  // A refused put moves no pointer.
  assert_put_full_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && put_i && !commit_i && !rollback_i) |=> $stable(tw_q));
  // A refused got moves no pointer.
  assert_got_empty_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o) |=> (rd_q == $past(rd_q)));
  // Rollback returns the tentative pointer to the committed one.
  assert_rollback_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rollback_i && !commit_i) |=> (tw_q == $past(cw_q)) && $stable(cw_q));
  // After a commit nothing is pending.
  assert_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !rollback_i) |=> (cw_q == tw_q));
endmodule

// File: rtl/txn_fifo_store.sv
module txn_fifo_store #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == AW'(i))) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/txn_fifo_level.sv
module txn_fifo_level #(
  parameter int AW = 4,
  parameter int QW = 2,
  localparam int OW = (QW > 0) ? QW : 1
) (
  input  logic [AW:0]   cnt_i,
  output logic [OW-1:0] lvl_o
);
  localparam int CW = ((QW > AW) ? QW : AW) + 1;

  if (QW == 0) begin : g_off
    logic unused;
    assign unused = ^cnt_i;
    assign lvl_o  = '0;
  end else begin : g_on
    logic [CW-1:0] wide, scaled;
    assign wide = CW'(cnt_i);
    if (QW <= AW) begin : g_down
      assign scaled = wide >> (AW - QW);
    end else begin : g_up
      assign scaled = wide << (QW - AW);
    end
    assign lvl_o = (scaled > CW'((1 << QW) - 1)) ? '1 : scaled[OW-1:0];
  end
endmodule

// File: rtl/txn_fifo.sv
module txn_fifo
  import txn_fifo_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MIN_DEPTH = 12,
  parameter int FILL_QW   = 2,
  parameter int FREE_QW   = 2,
  localparam int AW       = pow2_ceil_log(MIN_DEPTH),
  localparam int FILL_OW  = (FILL_QW > 0) ? FILL_QW : 1,
  localparam int FREE_OW  = (FREE_QW > 0) ? FREE_QW : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               put_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               commit_i,
  input  logic               rollback_i,
  output logic               full_o,
  output logic [FREE_OW-1:0] free_lvl_o,
  input  logic               got_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               valid_o,
  output logic [FILL_OW-1:0] fill_lvl_o
);
  localparam logic [AW:0] DEPTH = (AW+1)'(1 << AW);

  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [AW:0]   used, occ, free_cnt;

  txn_fifo_ptrs #(.AW(AW)) i_ptrs (
    .clk_i, .rst_ni, .put_i, .commit_i, .rollback_i, .got_i,
    .full_o, .valid_o,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .rd_addr_o(rd_addr),
    .used_o(used), .occ_o(occ)
  );

  txn_fifo_store #(.DW(DATA_W), .AW(AW)) i_store (
    .clk_i, .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(data_i),
    .raddr_i(rd_addr), .rdata_o(data_o)
  );

  assign free_cnt = DEPTH - occ;

  txn_fifo_level #(.AW(AW), .QW(FILL_QW)) i_fill_lvl (
    .cnt_i(used), .lvl_o(fill_lvl_o)
  );

  txn_fifo_level #(.AW(AW), .QW(FREE_QW)) i_free_lvl (
    .cnt_i(free_cnt), .lvl_o(free_lvl_o)
  );

  assert_full_means_no_free_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (free_lvl_o == '0));
  assert_valid_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_lvl_o != '0) |-> valid_o);
endmodule

// File: tb/test_txn_fifo.sv
module test_txn_fifo;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int QW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic put = 1'b0, commit = 1'b0, rollback = 1'b0, got = 1'b0;
  logic [DW-1:0] din = '0;
  logic full, valid;
  logic [DW-1:0] dout;
  logic [QW-1:0] fill_lvl, free_lvl;

  int checks = 0;
  int errors = 0;

  int m_rd = 0, m_cw = 0, m_tw = 0;
  logic [DW-1:0] m_mem [DEPTH];

  always #5 clk = ~clk;

  txn_fifo #(.DATA_W(DW), .MIN_DEPTH(12), .FILL_QW(QW), .FREE_QW(QW)) i_txn_fifo (
    .clk_i(clk), .rst_ni(rst_n), .put_i(put), .data_i(din),
    .commit_i(commit), .rollback_i(rollback), .full_o(full),
    .free_lvl_o(free_lvl), .got_i(got), .data_o(dout),
    .valid_o(valid), .fill_lvl_o(fill_lvl)
  );

  function automatic int quant(input int c);
    int q;
    q = (c * (1 << QW)) / DEPTH;
    return (q > (1 << QW) - 1) ? (1 << QW) - 1 : q;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    bit e_valid, e_full;
    e_valid = (m_cw != m_rd);
    e_full  = ((m_tw - m_rd) == DEPTH);
    check(valid == e_valid, "R3 valid", int'(valid), int'(e_valid));
    check(full == e_full, "R6 full", int'(full), int'(e_full));
    if (e_valid)
      check(dout == m_mem[m_rd % DEPTH], "R2 data", int'(dout), int'(m_mem[m_rd % DEPTH]));
    check(int'(fill_lvl) == quant(m_cw - m_rd), "R9 fill level", int'(fill_lvl), quant(m_cw - m_rd));
    check(int'(free_lvl) == quant(DEPTH - (m_tw - m_rd)), "R10 free level",
          int'(free_lvl), quant(DEPTH - (m_tw - m_rd)));
  endtask

  task automatic step(input bit p, input logic [DW-1:0] d, input bit c, input bit r, input bit g);
    bit f, v;
    @(negedge clk);
    put = p; din = d; commit = c; rollback = r; got = g;
    @(posedge clk);
    f = ((m_tw - m_rd) == DEPTH);
    v = (m_cw != m_rd);
    if (p && !f) begin
      m_mem[m_tw % DEPTH] = d;
      m_tw++;
    end
    if (g && v) m_rd++;
    if (c) m_cw = m_tw;
    else if (r) m_tw = m_cw;
    #1;
    compare_all();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(valid == 1'b0, "R1 valid", int'(valid), 0);
    check(full == 1'b0, "R1 full", int'(full), 0);
    check(fill_lvl == '0, "R1 fill", int'(fill_lvl), 0);
    check(free_lvl == '1, "R1 free", int'(free_lvl), 3);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 / R4: pending words hidden, commit with same-cycle put publishes all
    for (int i = 0; i < 3; i++) step(1, 8'h10 + 8'(i), 0, 0, 0);
    check(valid == 1'b0, "R3 pending hidden", int'(valid), 0);
    step(1, 8'h13, 1, 0, 0);
    check(valid == 1'b1, "R4 commit valid", int'(valid), 1);
    check(dout == 8'h10, "R4 head", int'(dout), 16);
    check(int'(fill_lvl) == 1, "R4 fill incl same-cycle put", int'(fill_lvl), 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1);
    check(valid == 1'b0, "R4 drained", int'(valid), 0);

    // R5: rollback with same-cycle put frees everything
    for (int i = 0; i < 10; i++) step(1, 8'h40 + 8'(i), 0, 0, 0);
    check(int'(free_lvl) == 1, "R5 free before", int'(free_lvl), 1);
    step(1, 8'h4A, 0, 1, 0);
    check(free_lvl == '1, "R5 free restored", int'(free_lvl), 3);
    check(valid == 1'b0, "R5 nothing readable", int'(valid), 0);
    step(1, 8'h77, 1, 0, 0);
    check(dout == 8'h77, "R5 discarded words gone", int'(dout), 119);
    step(0, 0, 0, 0, 1);

    // R11 / R6 / R7: exact depth, full while not valid, put while full ignored
    for (int i = 0; i < 15; i++) step(1, 8'h80 + 8'(i), 0, 0, 0);
    check(full == 1'b0, "R11 not full at 15", int'(full), 0);
    step(1, 8'h8F, 0, 0, 0);
    check(full == 1'b1, "R11 full at 16", int'(full), 1);
    check(valid == 1'b0, "R6 full and not valid", int'(valid), 0);
    step(1, 8'hEE, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    for (int i = 0; i < 16; i++) begin
      check(dout == 8'h80 + 8'(i), "R7 order after refused put", int'(dout), 128 + i);
      step(0, 0, 0, 0, 1);
    end
    check(valid == 1'b0, "R7 refused word absent", int'(valid), 0);

    // R8: got while empty ignored
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(1, 8'h5A, 1, 0, 0);
    check(dout == 8'h5A, "R8 got on empty ignored", int'(dout), 90);
    check(valid == 1'b1, "R8 valid", int'(valid), 1);
    step(0, 0, 0, 0, 1);

    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      int sel;
      bit c, r;
      sel = int'($urandom_range(0, 99));
      c = (sel < 12);
      r = (sel >= 12) && (sel < 20);
      step(($urandom_range(0, 9) < 6), DW'($urandom), c, r, ($urandom_range(0, 9) < 5));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule